// File: doc/BRIEF.md
# PHY Test-Port Register Write Sequencer

This block performs a single write into a configuration register inside a PHY through its serial test port. The port consists of a clear line, a strobe that the PHY uses as a clock, an enable line that marks the bus content as an address, and an 8-bit bus that carries both the address and the data. A host applies an 8-bit register code and an 8-bit value, and pulses a start input. The block then steps through a fixed pin sequence and signals completion.

The sequence has eight phases. Each phase holds for a programmable number of system clocks, so the setup and hold times at the PHY pins are met. The port is cleared first. The strobe is then raised, and the enable line and the code are applied. The strobe falls to latch the address. Next the enable line is dropped and the value is applied, and the strobe rises to latch the data. The strobe then returns low. For example, code 0x44 selects the high-speed frequency band register. The code and value are captured when the write is accepted, and the pin outputs come from flops, so the strobe never glitches.

Top module: `tport_wr_seq`

## Requirements
- R1: After reset and while idle, busy_o, done_o, tclr_o, tstb_o and ten_o are 0 and tdat_o is 0 (default bus parking at zero).
- R2: In the first cycle after an accepted start, the clear phase begins: tclr_o=1, tstb_o=0, ten_o=0 and tdat_o=0. After it comes a release phase in which all four outputs are 0.
- R3: The third phase drives tstb_o=1 with ten_o=0, tclr_o=0 and tdat_o=0.
- R4: The fourth phase drives ten_o=1, tdat_o=code and tstb_o=1. The fifth phase keeps ten_o=1 and tdat_o=code and drives tstb_o=0, so the address is latched on a falling strobe edge.
- R5: The sixth phase drives ten_o=0, tdat_o=value and tstb_o=0. The seventh phase keeps ten_o=0 and tdat_o=value and drives tstb_o=1, so the data is latched on a rising strobe edge.
- R6: The eighth phase drives tstb_o=0 with tclr_o=0 and ten_o=0 and keeps tdat_o=value. After it, tdat_o returns to 0.
- R7: Every phase lasts exactly HOLD system clocks, where HOLD is at least 2. A full write keeps busy_o high for 8*HOLD cycles.
- R8: busy_o is high from the cycle after an accepted start through the last cycle of the eighth phase. In the next cycle, done_o is 1 for exactly one cycle and busy_o is 0.
- R9: A start that is high while busy_o is 1 is ignored, including a start in the last busy cycle. The pin sequence in progress continues unchanged, and no second write follows.
- R10: The code and value are captured at acceptance. Changes on code_i and data_i during the write do not change tdat_o.
- R11: A start that is high in the done cycle is accepted, so the next write's clear phase starts in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Write request; taken only when idle |
| code_i | input | DW | Register code (address) to write |
| data_i | input | DW | Value to write |
| busy_o | output | 1 | Write sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| tclr_o | output | 1 | Test-port clear line |
| tstb_o | output | 1 | Test-port strobe |
| ten_o | output | 1 | Test-port enable (address qualifier) |
| tdat_o | output | DW | Test-port shared address/data bus |

## Verification
Two events can fall in the same cycle: completion of one write and a new start request. The bench raises start_i in the last busy cycle, where it must be ignored, and it also raises start_i in the done cycle, where it must launch a new write at once. A scoreboard holds the expected per-cycle pin image for each write. The bench judges these two cases by whether the expected pin images come out with no gap and no extra write. A start that arrives in the middle of a write, together with changed code and value inputs, is judged the same way: the recorded pin sequence must stay the one that was captured at acceptance.

// File: rtl/tport_pkg.sv
package tport_pkg;

   typedef enum logic [3:0] {
      PH_IDLE = 4'd0,
      PH_CLR  = 4'd1,
      PH_REL  = 4'd2,
      PH_STBH = 4'd3,
      PH_ADDR = 4'd4,
      PH_ALAT = 4'd5,
      PH_DATA = 4'd6,
      PH_DLAT = 4'd7,
      PH_END  = 4'd8
   } phase_e;

   typedef struct packed {
      logic clr;
      logic stb;
      logic en;
   } ctl_t;

   function automatic phase_e phase_after(phase_e p);
      phase_e n;
      case (p)
         PH_CLR:  n = PH_REL;
         PH_REL:  n = PH_STBH;
         PH_STBH: n = PH_ADDR;
         PH_ADDR: n = PH_ALAT;
         PH_ALAT: n = PH_DATA;
         PH_DATA: n = PH_DLAT;
         PH_DLAT: n = PH_END;
         default: n = PH_IDLE;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/tport_hold_timer.sv
module tport_hold_timer #(
   parameter int HOLD = 4,
   localparam int CW = (HOLD > 2) ? $clog2(HOLD) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   output logic expire_o
);

   localparam logic [CW-1:0] RELOAD = CW'(HOLD - 1);

   logic [CW-1:0] cnt_q;

   generate
      if (HOLD < 2) begin : g_bad_hold
         $error("tport_hold_timer: HOLD must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load_i)
         cnt_q <= RELOAD;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expire_o = (cnt_q == '0);

   // R7: the count never leaves its programmed window
   a_r7_cnt_window: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= RELOAD);

   // R7: a reload is followed by a non-expired cycle
   a_r7_load_holds: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> !expire_o);

endmodule

// File: rtl/tport_pin_map.sv
module tport_pin_map
   import tport_pkg::*;
#(
   parameter int DW        = 8,
   parameter bit PARK_ZERO = 1'b1
) (
   input  phase_e        phase_i,
   input  logic [DW-1:0] code_i,
   input  logic [DW-1:0] data_i,
   output ctl_t          ctl_o,
   output logic [DW-1:0] bus_o
);

   logic [DW-1:0] park_bus;

   generate
      if (PARK_ZERO) begin : g_park_zero
         assign park_bus = '0;
      end else begin : g_park_hold
         assign park_bus = data_i;
      end
   endgenerate

   always_comb begin
      ctl_o = '{clr: 1'b0, stb: 1'b0, en: 1'b0};
      bus_o = '0;
      case (phase_i)
         PH_CLR:  ctl_o.clr = 1'b1;
         PH_REL:  ;
         PH_STBH: ctl_o.stb = 1'b1;
         PH_ADDR: begin
            ctl_o.stb = 1'b1;
            ctl_o.en  = 1'b1;
            bus_o     = code_i;
         end
         PH_ALAT: begin
            ctl_o.en = 1'b1;
            bus_o    = code_i;
         end
         PH_DATA: bus_o = data_i;
         PH_DLAT: begin
            ctl_o.stb = 1'b1;
            bus_o     = data_i;
         end
         PH_END:  bus_o = data_i;
         default: bus_o = park_bus;
      endcase
   end

endmodule

// File: rtl/tport_wr_seq.sv
module tport_wr_seq
   import tport_pkg::*;
#(
   parameter int DW        = 8,
   parameter int HOLD      = 4,
   parameter bit PARK_ZERO = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [DW-1:0] code_i,
   input  logic [DW-1:0] data_i,
   output logic          busy_o,
   output logic          done_o,
   output logic          tclr_o,
   output logic          tstb_o,
   output logic          ten_o,
   output logic [DW-1:0] tdat_o
);

   generate
      if (DW < 1) begin : g_bad_dw
         $error("tport_wr_seq: DW must be positive");
      end
   endgenerate

   phase_e        phase_q, phase_d;
   logic [DW-1:0] code_q, data_q, code_d, data_d;
   logic          accept, expire, load, done_q;
   ctl_t          ctl_d, ctl_q;
   logic [DW-1:0] bus_d, bus_q;

   assign accept = start_i && (phase_q == PH_IDLE);

   always_comb begin
      phase_d = phase_q;
      code_d  = code_q;
      data_d  = data_q;
      if (accept) begin
         phase_d = PH_CLR;
         code_d  = code_i;
         data_d  = data_i;
      end else if (phase_q != PH_IDLE && expire) begin
         phase_d = phase_after(phase_q);
      end
   end

   assign load = accept || (phase_q != PH_IDLE && phase_q != PH_END && expire);

   tport_hold_timer #(.HOLD(HOLD)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load),
      .expire_o (expire)
   );

   tport_pin_map #(.DW(DW), .PARK_ZERO(PARK_ZERO)) u_map (
      .phase_i (phase_d),
      .code_i  (code_d),
      .data_i  (data_d),
      .ctl_o   (ctl_d),
      .bus_o   (bus_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         code_q  <= '0;
         data_q  <= '0;
         done_q  <= 1'b0;
         ctl_q   <= '0;
         bus_q   <= '0;
      end else begin
         phase_q <= phase_d;
         code_q  <= code_d;
         data_q  <= data_d;
         done_q  <= (phase_q == PH_END) && (phase_d == PH_IDLE);
         ctl_q   <= ctl_d;
         bus_q   <= bus_d;
      end
   end

   assign busy_o = (phase_q != PH_IDLE);
   assign done_o = done_q;
   assign tclr_o = ctl_q.clr;
   assign tstb_o = ctl_q.stb;
   assign ten_o  = ctl_q.en;
   assign tdat_o = bus_q;

   // R8: completion pulse never overlaps busy and lasts one cycle
   a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);
   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R8: busy only starts from a start request
   a_r8_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i));
   // R2: clear is never combined with other port activity
   a_r2_clr_alone: assert property (@(posedge clk) disable iff (!rst_n)
      tclr_o |-> (!tstb_o && !ten_o && tdat_o == '0));
   // R4: enable rises while the strobe is already high
   a_r4_en_under_stb: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ten_o) |-> tstb_o);
   // R5: enable drops only after the strobe went low
   a_r5_en_drop_low: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ten_o) |-> !tstb_o);
   // R10: captured operands stay frozen during a write
   a_r10_operands_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> ($stable(code_q) && $stable(data_q)));
   // R1: idle port is quiet
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!tclr_o && !tstb_o && !ten_o));

endmodule

// File: tb/tport_wr_seq_test.sv
module tport_wr_seq_test;

   localparam int CLK_PERIOD = 10;
   localparam int DW         = 8;
   localparam int HOLD       = 3;
   localparam int RUN_LEN    = 8 * HOLD;
   localparam int WATCHDOG   = 20000;

   typedef struct packed {
      logic          busy;
      logic          done;
      logic          clr;
      logic          stb;
      logic          en;
      logic [DW-1:0] bus;
      logic [3:0]    req;
   } item_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [DW-1:0] code_i = '0;
   logic [DW-1:0] data_i = '0;
   logic          busy_o, done_o, tclr_o, tstb_o, ten_o;
   logic [DW-1:0] tdat_o;

   int    n_tests = 0;
   int    n_fail  = 0;
   bit    mon_on  = 1'b0;
   string ctx     = "reset";
   item_t exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   tport_wr_seq #(.DW(DW), .HOLD(HOLD), .PARK_ZERO(1'b1)) uut (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .code_i  (code_i),
      .data_i  (data_i),
      .busy_o  (busy_o),
      .done_o  (done_o),
      .tclr_o  (tclr_o),
      .tstb_o  (tstb_o),
      .ten_o   (ten_o),
      .tdat_o  (tdat_o)
   );

   function automatic string req_name(logic [3:0] r);
      case (r)
         4'd1: return "R1";
         4'd2: return "R2";
         4'd3: return "R3";
         4'd4: return "R4";
         4'd5: return "R5";
         4'd6: return "R6";
         default: return "R8";
      endcase
   endfunction

   function automatic item_t mk(logic b, logic d, logic c, logic s, logic e,
                                logic [DW-1:0] v, logic [3:0] r);
      item_t it;
      it.busy = b; it.done = d; it.clr = c; it.stb = s; it.en = e;
      it.bus = v; it.req = r;
      return it;
   endfunction

   task automatic compare(item_t ex);
      item_t ac;
      ac = mk(busy_o, done_o, tclr_o, tstb_o, ten_o, tdat_o, ex.req);
      n_tests++;
      if (ac != ex) begin
         n_fail++;
         $display("FAIL %s [%s] actual busy%0b done%0b clr%0b stb%0b en%0b bus%02h expected busy%0b done%0b clr%0b stb%0b en%0b bus%02h",
                  req_name(ex.req), ctx, ac.busy, ac.done, ac.clr, ac.stb, ac.en, ac.bus,
                  ex.busy, ex.done, ex.clr, ex.stb, ex.en, ex.bus);
      end
   endtask

   // Expected pin image for one write; each phase HOLD cycles (R7)
   task automatic push_write(logic [DW-1:0] c, logic [DW-1:0] d);
      for (int i = 0; i < HOLD; i++) exp_q.push_back(mk(1, 0, 1, 0, 0, '0, 4'd2));
      for (int i = 0; i < HOLD; i++) exp_q.push_back(mk(1, 0, 0, 0, 0, '0, 4'd2));
      for (int i = 0; i < HOLD; i++) exp_q.push_back(mk(1, 0, 0, 1, 0, '0, 4'd3));
      for (int i = 0; i < HOLD; i++) exp_q.push_back(mk(1, 0, 0, 1, 1, c,  4'd4));
      for (int i = 0; i < HOLD; i++) exp_q.push_back(mk(1, 0, 0, 0, 1, c,  4'd4));
      for (int i = 0; i < HOLD; i++) exp_q.push_back(mk(1, 0, 0, 0, 0, d,  4'd5));
      for (int i = 0; i < HOLD; i++) exp_q.push_back(mk(1, 0, 0, 1, 0, d,  4'd5));
      for (int i = 0; i < HOLD; i++) exp_q.push_back(mk(1, 0, 0, 0, 0, d,  4'd6));
      exp_q.push_back(mk(0, 1, 0, 0, 0, '0, 4'd8));
   endtask

   // Monitor: one comparison per cycle, just after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (mon_on) begin
            if (exp_q.size() != 0) compare(exp_q.pop_front());
            else compare(mk(0, 0, 0, 0, 0, '0, 4'd1));
         end
      end
   end

   // Driver: called at a falling edge; returns at the falling edge of the done cycle
   task automatic run_write(logic [DW-1:0] c, logic [DW-1:0] d, bit disturb);
      start_i = 1'b1;
      code_i  = c;
      data_i  = d;
      @(posedge clk);
      push_write(c, d);
      for (int i = 1; i <= RUN_LEN; i++) begin
         @(negedge clk);
         if (i == 1) begin
            start_i = 1'b0;
            if (disturb) begin
               code_i = ~c;
               data_i = d ^ 8'h5A;
            end
         end
         if (disturb && i == 2) start_i = 1'b1;
         if (disturb && i == 3) start_i = 1'b0;
         if (disturb && i == RUN_LEN) start_i = 1'b1;
         @(posedge clk);
      end
      @(negedge clk);
      start_i = 1'b0;
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired [%s] actual running expected finished", ctx);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      ctx = "R1 in reset";
      compare(mk(0, 0, 0, 0, 0, '0, 4'd1));
      rst_n = 1'b1;
      @(negedge clk);
      mon_on = 1'b1;
      ctx = "R1 idle after reset";
      repeat (3) @(negedge clk);

      ctx = "R2 R7 band register code 0x44";
      run_write(8'h44, 8'h2C, 1'b0);
      repeat (2) @(negedge clk);

      ctx = "R4 R5 zero code full value";
      run_write(8'h00, 8'hFF, 1'b0);
      repeat (2) @(negedge clk);

      ctx = "R6 full code zero value";
      run_write(8'hFF, 8'h00, 1'b0);
      repeat (2) @(negedge clk);

      ctx = "R9 R10 start and operand changes while busy";
      run_write(8'hA5, 8'h3C, 1'b1);

      ctx = "R11 start in done cycle";
      run_write(8'h5E, 8'h81, 1'b0);
      ctx = "R11 second back-to-back write";
      run_write(8'h12, 8'h34, 1'b0);
      repeat (4) @(negedge clk);

      ctx = "R8 drained";
      n_tests++;
      if (exp_q.size() != 0) begin
         n_fail++;
         $display("FAIL R8 [%s] actual %0d pending expected 0 pending", ctx, exp_q.size());
      end
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule